// File: doc/BRIEF.md
# Video Memory Rectangle Transfer Engine

This block moves a rectangle of 16-bit pixels between a 32-bit data port and a 1024 x 512 pixel memory. A start pulse loads a position word, a size word and a direction. The engine then walks the rectangle row by row, left to right, and issues one pixel access per memory cycle. Each 32-bit word on the data port carries two pixels. A word can begin on one row and end on the next, so the column reached so far carries over from one word to the next.

For a write, the engine accepts a word whenever `wr_ready` is high and stores its two halves in turn. For a read, the engine fetches two pixels ahead and presents them on `rd_word` with `rd_valid`. `img_ready` stays high from the start of a read until the last word is taken. When the last pixel has been handled, `busy` falls and `done` pulses for one cycle. The memory is a simple synchronous pixel port: read data appears one clock after the address.

The control state machine has these states: IDLE, WR_WAIT, WR_LO, WR_HI, RD_LO, RD_HI, RD_CAP, RD_LAST and RD_HOLD.

Transitions:
- Any state goes to IDLE on abort.
- Any state goes to WR_WAIT or RD_LO on start. Abort wins over start.
- IDLE stays in IDLE until a start.
- WR_WAIT goes to WR_LO when a word is accepted.
- WR_LO goes to WR_HI, or to IDLE if it wrote the final pixel.
- WR_HI goes back to WR_WAIT, or to IDLE if it wrote the final pixel.
- RD_LO goes to RD_HI, or to RD_LAST if the pixel it fetched was the final one.
- RD_HI goes to RD_CAP.
- RD_CAP goes to RD_HOLD.
- RD_LAST goes to RD_HOLD.
- RD_HOLD goes back to RD_LO when the word is taken, or to IDLE when the word taken held the final pixel.

Top module: `vram_rect_xfer`

## Requirements
- R1: The start column is `pos_word[9:0]` and the start row is `pos_word[24:16]`; all other position bits are ignored.
- R2: The width is `((size_word[9:0] - 1) mod 1024) + 1`, so a field of 0 selects 1024 columns; other low-half bits are ignored.
- R3: The height is `((size_word[24:16] - 1) mod 512) + 1`, so a field of 0 selects 512 rows.
- R4: The pixel address is `row*1024 + column` on the 19-bit `mem_addr`. Within a data word, bits 15:0 are the first pixel and bits 31:16 the second.
- R5: Pixels are visited row by row, each row from left to right. The row number wraps from 511 to 0 during a transfer.
- R6: The column wraps from 1023 to 0 within a row.
- R7: A word that ends partway through a row leaves the column position for the next word. A word may span two rows.
- R8: A write consumes one word per `wr_valid` while `wr_ready` is high and issues exactly width*height pixel writes. The upper half of the last word is dropped when the pixel count is odd.
- R9: Starting a read raises `img_ready` on the next cycle. The first word offered on `rd_word` holds the first two pixels. When the count is odd, the final word's upper half is zero.
- R10: After the last pixel is written, or the last read word is taken, `busy` and `img_ready` are low and `done` is high for exactly one cycle.
- R11: `xfer_abort` returns the engine to idle on the next clock. `busy`, `img_ready`, `wr_ready` and `rd_valid` go low, no further memory access follows, and `done` does not pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | Start pulse; loads position, size and direction |
| xfer_read | input | 1 | Direction at start: 1 = memory to port, 0 = port to memory |
| pos_word | input | 32 | Rectangle origin (column and row fields) |
| size_word | input | 32 | Rectangle size (width and height fields) |
| xfer_abort | input | 1 | Cancels any transfer at once |
| wr_valid | input | 1 | Write word offered |
| wr_word | input | 32 | Write word, two pixels |
| wr_ready | output | 1 | Engine can take a write word this cycle |
| rd_take | input | 1 | Consumes the word on `rd_word` |
| rd_word | output | 32 | Read word, two pixels |
| rd_valid | output | 1 | `rd_word` holds fresh pixels |
| img_ready | output | 1 | Read transfer has data pending |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 19 | Pixel address |
| mem_we | output | 1 | Pixel write strobe |
| mem_wdata | output | 16 | Pixel write data |
| mem_re | output | 1 | Pixel read strobe |
| mem_rdata | input | 16 | Pixel read data, one cycle after `mem_re` |

## Verification
A wrong column or row counter shows up on `mem_addr` at the very next pixel access. The most sensitive points are the places where a word straddles a row end, or where the row or column wraps. The bench therefore compares every logged address against an independently computed raster order.

A wrong row count, or a wrong final-pixel decision, shows as an extra or missing memory access. It also shows as a `done` pulse that comes early, comes late or never comes. Both are visible within one word of the rectangle end.

On reads, a stale pixel register or a mis-captured pixel appears directly on `rd_word` the first time the word is offered. A broken abort path leaves `busy` or `img_ready` high one cycle after the abort.

// File: rtl/vxfer_pkg.sv
package vxfer_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WR_WAIT,
        S_WR_LO,
        S_WR_HI,
        S_RD_LO,
        S_RD_HI,
        S_RD_CAP,
        S_RD_LAST,
        S_RD_HOLD
    } xfer_state_t;

endpackage

// File: rtl/vxfer_decode.sv
module vxfer_decode #(
    parameter int XW = 10,
    parameter int YW = 9
) (
    input  logic [31:0]   pos_word,
    input  logic [31:0]   size_word,
    output logic [XW-1:0] x0,
    output logic [YW-1:0] y0,
    output logic [XW:0]   wid,
    output logic [YW:0]   hgt
);
    localparam int YLSB = 16;

    logic [XW-1:0] wm1;
    logic [YW-1:0] hm1;
    logic          unused_fields;

    assign x0  = pos_word[XW-1:0];
    assign y0  = pos_word[YLSB +: YW];

    // Minus-one-then-plus-one: a zero field wraps to full size.
    assign wm1 = size_word[XW-1:0] - {{(XW-1){1'b0}}, 1'b1};
    assign hm1 = size_word[YLSB +: YW] - {{(YW-1){1'b0}}, 1'b1};
    assign wid = {1'b0, wm1} + {{XW{1'b0}}, 1'b1};
    assign hgt = {1'b0, hm1} + {{YW{1'b0}}, 1'b1};

    assign unused_fields = ^{pos_word, size_word};

    always_comb begin
        a_r2_width_range : assert (wid != '0);
        a_r3_height_range : assert (hgt != '0);
    end

endmodule

// File: rtl/vxfer_walker.sv
module vxfer_walker #(
    parameter int XW = 10,
    parameter int YW = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [XW-1:0]   x0,
    input  logic [YW-1:0]   y0,
    input  logic [XW:0]     wid,
    input  logic [YW:0]     hgt,
    input  logic            step,
    output logic [XW+YW-1:0] addr,
    output logic            last
);
    localparam int AW = XW + YW;

    logic [XW-1:0] xbase;
    logic [XW:0]   col_max;
    logic [XW:0]   col;
    logic [YW-1:0] row;
    logic [YW:0]   rows_left;
    logic          col_end;
    logic [XW-1:0] xcur;

    assign col_end = (col == col_max);
    assign last    = col_end && (rows_left == {{YW{1'b0}}, 1'b1});
    assign xcur    = xbase + col[XW-1:0];
    assign addr    = {row, xcur};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xbase     <= '0;
            col_max   <= '0;
            col       <= '0;
            row       <= '0;
            rows_left <= '0;
        end else if (load) begin
            xbase     <= x0;
            col_max   <= wid - {{XW{1'b0}}, 1'b1};
            col       <= '0;
            row       <= y0;
            rows_left <= hgt;
        end else if (step) begin
            if (col_end) begin
                col       <= '0;
                row       <= row + {{(YW-1){1'b0}}, 1'b1};
                rows_left <= rows_left - {{YW{1'b0}}, 1'b1};
            end else begin
                col <= col + {{XW{1'b0}}, 1'b1};
            end
        end
    end

    a_r5_step_has_rows : assert property (@(posedge clk) disable iff (!rst_n)
        step && !load |-> rows_left != '0);

    a_r7_col_in_row : assert property (@(posedge clk) disable iff (!rst_n)
        rows_left != '0 |-> col <= col_max);

    a_r5_row_advance : assert property (@(posedge clk) disable iff (!rst_n)
        step && !load && col_end |=> col == '0);

    logic unused_aw;
    assign unused_aw = (AW == 0);

endmodule

// File: rtl/vxfer_ctrl.sv
module vxfer_ctrl
    import vxfer_pkg::*;
#(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_read,
    input  logic          abort,
    input  logic          wr_valid,
    input  logic [2*PW-1:0] wr_word,
    input  logic          rd_take,
    input  logic          last,
    input  logic [PW-1:0] mem_rdata,
    output logic          load,
    output logic          step,
    output logic          mem_we,
    output logic          mem_re,
    output logic [PW-1:0] mem_wdata,
    output logic          wr_ready,
    output logic          rd_valid,
    output logic [2*PW-1:0] rd_word,
    output logic          img_ready,
    output logic          busy,
    output logic          done
);
    xfer_state_t state, nxt;

    logic [2*PW-1:0] word_q;
    logic [PW-1:0]   lo_q, hi_q;
    logic            final_q, img_q, done_q;
    logic            quiet, wr_px, rd_px, fin;

    assign quiet = !abort && !start;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Next state
    always_comb begin
        nxt = state;
        if (abort) begin
            nxt = S_IDLE;
        end else if (start) begin
            nxt = start_read ? S_RD_LO : S_WR_WAIT;
        end else begin
            unique case (state)
                S_IDLE:    nxt = S_IDLE;
                S_WR_WAIT: nxt = wr_valid ? S_WR_LO : S_WR_WAIT;
                S_WR_LO:   nxt = last ? S_IDLE : S_WR_HI;
                S_WR_HI:   nxt = last ? S_IDLE : S_WR_WAIT;
                S_RD_LO:   nxt = last ? S_RD_LAST : S_RD_HI;
                S_RD_HI:   nxt = S_RD_CAP;
                S_RD_CAP:  nxt = S_RD_HOLD;
                S_RD_LAST: nxt = S_RD_HOLD;
                S_RD_HOLD: nxt = rd_take ? (final_q ? S_IDLE : S_RD_LO) : S_RD_HOLD;
                default:   nxt = S_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        wr_px     = (state == S_WR_LO) || (state == S_WR_HI);
        rd_px     = (state == S_RD_LO) || (state == S_RD_HI);
        load      = start && !abort;
        step      = quiet && (wr_px || rd_px);
        mem_we    = quiet && wr_px;
        mem_re    = quiet && rd_px;
        mem_wdata = (state == S_WR_HI) ? word_q[2*PW-1:PW] : word_q[PW-1:0];
        wr_ready  = (state == S_WR_WAIT);
        rd_valid  = (state == S_RD_HOLD);
        rd_word   = {hi_q, lo_q};
        busy      = (state != S_IDLE);
        img_ready = img_q;
        done      = done_q;
        fin       = quiet && ((wr_px && last) || ((state == S_RD_HOLD) && rd_take && final_q));
    end

    // Data path registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
            final_q <= 1'b0;
            img_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= fin;

            if (abort)     img_q <= 1'b0;
            else if (load) img_q <= start_read;
            else if (fin)  img_q <= 1'b0;

            if (load)                 final_q <= 1'b0;
            else if (mem_re && last)  final_q <= 1'b1;

            if (quiet && (state == S_WR_WAIT) && wr_valid) word_q <= wr_word;

            if (state == S_RD_HI) lo_q <= mem_rdata;
            if (state == S_RD_CAP) hi_q <= mem_rdata;
            if (state == S_RD_LAST) begin
                lo_q <= mem_rdata;
                hi_q <= '0;
            end
        end
    end

    a_r10_done_idle : assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !img_ready);

    a_r9_img_needs_busy : assert property (@(posedge clk) disable iff (!rst_n)
        img_ready |-> busy);

    a_r9_valid_means_img : assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> img_ready);

    a_r11_abort_idles : assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !busy && !img_ready && !done);

    a_r8_single_port_op : assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    a_r8_word_held : assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WR_LO) && quiet |=> $stable(word_q));

endmodule

// File: rtl/vram_rect_xfer.sv
module vram_rect_xfer #(
    parameter int XW = 10,
    parameter int YW = 9,
    parameter int PW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 xfer_start,
    input  logic                 xfer_read,
    input  logic [31:0]          pos_word,
    input  logic [31:0]          size_word,
    input  logic                 xfer_abort,
    input  logic                 wr_valid,
    input  logic [2*PW-1:0]      wr_word,
    output logic                 wr_ready,
    input  logic                 rd_take,
    output logic [2*PW-1:0]      rd_word,
    output logic                 rd_valid,
    output logic                 img_ready,
    output logic                 busy,
    output logic                 done,
    output logic [XW+YW-1:0]     mem_addr,
    output logic                 mem_we,
    output logic [PW-1:0]        mem_wdata,
    output logic                 mem_re,
    input  logic [PW-1:0]        mem_rdata
);
    logic [XW-1:0] x0;
    logic [YW-1:0] y0;
    logic [XW:0]   wid;
    logic [YW:0]   hgt;
    logic          load, step, last;

    vxfer_decode #(.XW(XW), .YW(YW)) u_decode (
        .pos_word (pos_word),
        .size_word(size_word),
        .x0       (x0),
        .y0       (y0),
        .wid      (wid),
        .hgt      (hgt)
    );

    vxfer_walker #(.XW(XW), .YW(YW)) u_walker (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .x0       (x0),
        .y0       (y0),
        .wid      (wid),
        .hgt      (hgt),
        .step     (step),
        .addr     (mem_addr),
        .last     (last)
    );

    vxfer_ctrl #(.PW(PW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (xfer_start),
        .start_read(xfer_read),
        .abort     (xfer_abort),
        .wr_valid  (wr_valid),
        .wr_word   (wr_word),
        .rd_take   (rd_take),
        .last      (last),
        .mem_rdata (mem_rdata),
        .load      (load),
        .step      (step),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_wdata (mem_wdata),
        .wr_ready  (wr_ready),
        .rd_valid  (rd_valid),
        .rd_word   (rd_word),
        .img_ready (img_ready),
        .busy      (busy),
        .done      (done)
    );

    a_r11_no_access_idle : assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we && !mem_re);

endmodule

// File: tb/vram_rect_xfer_test.sv
module vram_rect_xfer_test;
    localparam int CLK_NS = 10;
    localparam int WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_start = 1'b0, xfer_read = 1'b0, xfer_abort = 1'b0;
    logic [31:0] pos_word = '0, size_word = '0;
    logic        wr_valid = 1'b0, rd_take = 1'b0;
    logic [31:0] wr_word = '0;
    logic        wr_ready, rd_valid, img_ready, busy, done, mem_we, mem_re;
    logic [31:0] rd_word;
    logic [18:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;

    int n_cmp = 0, n_bad = 0, cyc = 0, done_cnt = 0;
    logic [18:0] la[$];
    logic [15:0] ld[$];

    always #(CLK_NS/2) clk = ~clk;

    vram_rect_xfer uut (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_read(xfer_read),
        .pos_word(pos_word), .size_word(size_word), .xfer_abort(xfer_abort),
        .wr_valid(wr_valid), .wr_word(wr_word), .wr_ready(wr_ready),
        .rd_take(rd_take), .rd_word(rd_word), .rd_valid(rd_valid),
        .img_ready(img_ready), .busy(busy), .done(done),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_rdata(mem_rdata)
    );

    function automatic logic [15:0] pat(input logic [18:0] a);
        return a[15:0] ^ {13'h0, a[18:16]} ^ 16'hA5C3;
    endfunction

    function automatic logic [15:0] pv(input int i);
        return 16'(i * 3 + 32'h1234);
    endfunction

    function automatic logic [18:0] paddr(input int x, input int y, input int w, input int i);
        int r, c;
        r = i / w;
        c = i % w;
        return 19'(((y + r) % 512) * 1024 + ((x + c) % 1024));
    endfunction

    // Synchronous pixel memory model, one-cycle read latency
    always @(posedge clk) if (mem_re) mem_rdata <= pat(mem_addr);

    always @(negedge clk) begin
        cyc++;
        if (mem_we) begin
            la.push_back(mem_addr);
            ld.push_back(mem_wdata);
        end
        if (done) done_cnt++;
        if (cyc > WATCHDOG) begin
            n_bad++;
            $display("FAIL watchdog (R8/R10) cycles=%0d expected below %0d", cyc, WATCHDOG);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic rd, input logic [31:0] p, input logic [31:0] s);
        @(negedge clk);
        xfer_start = 1'b1; xfer_read = rd; pos_word = p; size_word = s;
        @(negedge clk);
        xfer_start = 1'b0;
    endtask

    task automatic send_word(input logic [31:0] wv);
        int g = 0;
        while (!wr_ready && g < 100) begin @(negedge clk); g++; end
        wr_valid = 1'b1; wr_word = wv;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int g = 0;
        while (busy && g < 5000) begin @(negedge clk); g++; end
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R10 reset busy", busy, 0);
        chk("R10 reset img_ready", img_ready, 0);
        chk("R8 reset wr_ready", wr_ready, 0);
        chk("R9 reset rd_valid", rd_valid, 0);
        chk("R10 reset done", done, 0);
    endtask

    task automatic t_write(input string req, input int x, input int y, input int wf, input int hf,
                           input logic [31:0] pj, input logic [31:0] sj);
        int w, h, npix, nw, dc0, mism;
        w = (wf == 0) ? 1024 : wf;
        h = (hf == 0) ? 512 : hf;
        npix = w * h;
        nw = (npix + 1) / 2;
        la.delete(); ld.delete();
        dc0 = done_cnt;
        pulse_start(1'b0, pj | 32'(y << 16) | 32'(x), sj | 32'(hf << 16) | 32'(wf));
        for (int k = 0; k < nw; k++) send_word({pv(2*k+1), pv(2*k)});
        wait_idle();
        chk({req, " R8 write count"}, la.size(), npix);
        mism = 0;
        for (int i = 0; i < npix; i++) begin
            if (i >= la.size()) mism++;
            else if (la[i] !== paddr(x, y, w, i) || ld[i] !== pv(i)) mism++;
        end
        chk({req, " R4 address/data order"}, mism, 0);
        chk({req, " R10 done pulse count"}, done_cnt - dc0, 1);
        chk({req, " R10 busy low"}, busy, 0);
    endtask

    task automatic t_read(input string req, input int x, input int y, input int wf, input int hf);
        int w, h, npix, nw, dc0, mism, g;
        logic [31:0] ev;
        w = (wf == 0) ? 1024 : wf;
        h = (hf == 0) ? 512 : hf;
        npix = w * h;
        nw = (npix + 1) / 2;
        dc0 = done_cnt;
        mism = 0;
        pulse_start(1'b1, 32'(y << 16) | 32'(x), 32'(hf << 16) | 32'(wf));
        chk({req, " R9 img_ready after start"}, img_ready, 1);
        chk({req, " R9 busy after start"}, busy, 1);
        for (int k = 0; k < nw; k++) begin
            g = 0;
            while (!rd_valid && g < 100) begin @(negedge clk); g++; end
            ev[15:0]  = pat(paddr(x, y, w, 2*k));
            ev[31:16] = (2*k + 1 < npix) ? pat(paddr(x, y, w, 2*k+1)) : 16'h0;
            if (rd_word !== ev) begin
                mism++;
                if (mism == 1) $display("  first read mismatch word %0d", k);
            end
            if (k == 0) chk({req, " R9 first word preloaded"}, rd_word, ev);
            rd_take = 1'b1;
            @(negedge clk);
            rd_take = 1'b0;
        end
        @(negedge clk);
        chk({req, " R5 read stream"}, mism, 0);
        chk({req, " R10 img_ready cleared"}, img_ready, 0);
        chk({req, " R10 done pulse count"}, done_cnt - dc0, 1);
        chk({req, " R10 busy low"}, busy, 0);
    endtask

    task automatic t_abort_write();
        int dc0;
        la.delete(); ld.delete();
        dc0 = done_cnt;
        pulse_start(1'b0, 32'(50 << 16) | 32'd100, 32'h0004_0004);
        send_word(32'h1111_2222);
        while (!wr_ready) @(negedge clk);
        xfer_abort = 1'b1;
        @(negedge clk);
        xfer_abort = 1'b0;
        chk("R11 abort write busy", busy, 0);
        chk("R11 abort write wr_ready", wr_ready, 0);
        repeat (4) @(negedge clk);
        chk("R11 abort write no more writes", la.size(), 2);
        chk("R11 abort write no done", done_cnt - dc0, 0);
    endtask

    task automatic t_abort_read();
        int dc0;
        dc0 = done_cnt;
        pulse_start(1'b1, 32'd7, 32'h0002_0008);
        @(negedge clk);
        xfer_abort = 1'b1;
        @(negedge clk);
        xfer_abort = 1'b0;
        chk("R11 abort read img_ready", img_ready, 0);
        chk("R11 abort read busy", busy, 0);
        chk("R11 abort read rd_valid", rd_valid, 0);
        repeat (3) @(negedge clk);
        chk("R11 abort read no done", done_cnt - dc0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        // R1 R7: junk around fields, width 3 so a word spans two rows
        t_write("R1 R7 basic", 5, 3, 3, 2, 32'hFE00_FC00, 32'hFE00_FC00);
        // R5 R8: odd pixel count, row wrap 511 -> 0
        t_write("R5 R8 odd+wrap", 9, 511, 1, 3, 32'h0, 32'h0);
        // R6: column wrap within a row
        t_write("R6 xwrap", 1022, 40, 4, 1, 32'h0, 32'h0);
        // R2: zero width field means 1024
        t_write("R2 width zero", 0, 7, 0, 1, 32'h0, 32'h0);
        // R9: read with odd count
        t_read("R9 read odd", 10, 20, 3, 1);
        // R3: zero height field means 512 rows, wrapping from row 0
        t_read("R3 height zero", 3, 0, 1, 0);
        t_abort_write();
        t_abort_read();
        // R4: after abort a fresh transfer still works
        t_write("R4 after abort", 1, 1, 2, 2, 32'h0, 32'h0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule